// File: doc/BRIEF.md
# Sequenced Channel Trigger Engine

This block watches a bus of sampled digital channels, one new sample per clock, and raises a trigger when a programmed sequence of conditions has been seen. Each stage of the sequence holds a condition for every channel. A condition can be a level (high or low), an edge (rising or falling), or ignore. All channel conditions of a stage are combined with a logical AND. A stage can also require a glitch-width qualifier on one chosen channel: a pulse of the chosen polarity that is shorter than a programmed number of samples.

Stages must match one after another, from stage 0 up to a programmed final stage. This makes it possible to frame, for example, a header event, then a middle condition, then a tail event. The simplest use is a single stage with a falling-edge condition on one strobe channel. Software configures stages through a one-word write port. An arm level starts the search. When the final stage matches, the engine emits a single-cycle trigger pulse and then stays quiet until it is disarmed and armed again. A stage index output shows which stage is currently awaited.

Top module: `seq_trigger_engine`

## Requirements
- R1: After a synchronous active-low reset, the trigger is low and the stage index is 0. Every channel condition reads as ignore, the glitch qualifier is off and the final stage is 0. So arming right after reset triggers on the first armed sample.
- R2: Channel condition codes are 0 ignore, 1 high, 2 low, 3 rising, 4 falling. Codes 5 to 7 act as ignore. An edge compares the current sample with the previous sample of the same channel. The previous sample resets to all zeros.
- R3: A stage matches on a sample only when every channel condition of that stage holds on that same sample.
- R4: The trigger output is high for exactly one clock. It rises in the clock after the edge at which the sample satisfying the final stage was taken.
- R5: Stages are matched in order from 0 to the final stage, with at most one stage advance per sample. The stage index output shows the awaited stage and holds at the final stage after a trigger.
- R6: Glitch qualifier: the width is the number of consecutive samples at the active level, counted from the start edge. On the sample where the end edge appears, the qualifier hits if that width is below the threshold. A stage with the qualifier enabled matches only on a sample where it hits and all its channel conditions hold.
- R7: Qualifier polarity 0 measures high pulses (rising start, falling end). Polarity 1 measures low pulses (falling start, rising end).
- R8: While arm is low, the stage index is 0 and no trigger is produced, even if a stage condition holds on that sample. After a trigger, no further trigger occurs until arm goes low and then high again.
- R9: A configuration write (write enable high) selects its target with kind and stage. Kind 0 sets the condition of the channel given by the channel field to data[2:0]. Kind 1 sets the qualifier of the stage: channel field, threshold data[15:0], enable data[16] and polarity data[17]. Kind 2 sets the final stage to data, clamped to the last stage. Kind 3 is ignored. A write applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Level; high enables the search, low clears it |
| chan | input | NCH (32) | Sampled channel bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 condition, 1 qualifier, 2 final stage |
| cfg_stage | input | SW (2) | Stage addressed by the write |
| cfg_chan | input | CHW (5) | Channel addressed by the write |
| cfg_data | input | 32 | Write payload |
| trig | output | 1 | Single-cycle trigger pulse |
| stage_idx | output | SW (2) | Stage currently awaited |

## Verification
Two functions can land on the same sample: a condition that would complete the final stage, and the arm input falling. The bench provokes this by presenting a rising edge on the watched channel in the very sample where arm is low. It judges that neither a trigger nor a stage advance appears, and that a later edge with arm high still triggers. A second pairing is the glitch qualifier's end edge together with a pending stage match. Threshold and width sweeps put the hit exactly on the end-edge sample, and the bench checks the trigger in the following cycle.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
// Package: shared condition encoding and the per-channel condition test.
// Assumes samples arrive one per clock with the previous sample kept by the caller.
package trg_pkg;

    typedef enum logic [2:0] {
        COND_IGNORE  = 3'd0,
        COND_HIGH    = 3'd1,
        COND_LOW     = 3'd2,
        COND_RISE    = 3'd3,
        COND_FALL    = 3'd4
    } cond_e;

    // True when one channel satisfies its condition code; unused codes ignore.
    function automatic logic cond_hit(input logic [2:0] code,
                                      input logic cur,
                                      input logic prev);
        logic ok;
        case (code)
            COND_HIGH: ok = cur;
            COND_LOW:  ok = ~cur;
            COND_RISE: ok = cur & ~prev;
            COND_FALL: ok = ~cur & prev;
            default:   ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/trg_pulse_width.sv
`timescale 1ns/1ps
// Glitch-width qualifier for one stage. It measures the width, in samples, of a
// pulse of the chosen polarity on the chosen channel. The hit is flagged on the
// end-edge sample when the width is below the threshold.
// Assumes the channel select stays stable during a pulse of interest.
module trg_pulse_width #(
    parameter int NCH = 32,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           pol,
    input  logic [CHW-1:0] sel,
    input  logic [CW-1:0]  thr,
    input  logic [NCH-1:0] cur,
    input  logic [NCH-1:0] prev,
    output logic           hit
);

    logic          act_cur;
    logic          act_prev;
    logic          start_edge;
    logic          end_edge;
    logic          valid_q;
    logic [CW-1:0] cnt_q;

    // Normalise the watched channel so the active level is always 1.
    always_comb begin
        act_cur    = cur[sel] ^ pol;
        act_prev   = prev[sel] ^ pol;
        start_edge = act_cur & ~act_prev;
        end_edge   = ~act_cur & act_prev;
    end

    // Count active samples from the start edge, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start_edge) begin
            valid_q <= 1'b1;
            cnt_q   <= CW'(1);
        end else if (end_edge) begin
            valid_q <= 1'b0;
        end else if (valid_q && cnt_q != '1) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Qualifier result on the end-edge sample.
    always_comb hit = en & valid_q & end_edge & (cnt_q < thr);

    AST_PW_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cnt_q != '0)); // R6
    AST_PW_START_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |=> (valid_q && cnt_q == CW'(1))); // R7

endmodule

// File: rtl/trg_stage.sv
`timescale 1ns/1ps
// One trigger stage. It holds the per-channel condition codes and the glitch
// qualifier settings, and reports whether the current sample satisfies them all.
// Assumes configuration writes are decoded for this stage by the IDX parameter.
module trg_stage #(
    parameter int NCH = 32,
    parameter int CW  = 16,
    parameter int SW  = 2,
    parameter int IDX = 0,
    localparam int CHW = $clog2(NCH),
    localparam int DW  = CW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_kind,
    input  logic [SW-1:0]  cfg_stage,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [DW-1:0]  cfg_data,
    input  logic [NCH-1:0] cur,
    input  logic [NCH-1:0] prev,
    output logic           match
);

    logic [2:0]     cond_q [NCH];
    logic           pen_q;
    logic           pol_q;
    logic [CHW-1:0] psel_q;
    logic [CW-1:0]  thr_q;
    logic           wr_here;
    logic [NCH-1:0] chan_ok;
    logic           pw_hit;

    // Decode writes aimed at this stage.
    always_comb wr_here = cfg_we && (cfg_stage == SW'(IDX));

    // Store channel condition codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) cond_q[c] <= trg_pkg::COND_IGNORE;
        end else if (wr_here && cfg_kind == 2'd0) begin
            cond_q[cfg_chan] <= cfg_data[2:0];
        end
    end

    // Store glitch qualifier settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q  <= 1'b0;
            pol_q  <= 1'b0;
            psel_q <= '0;
            thr_q  <= '0;
        end else if (wr_here && cfg_kind == 2'd1) begin
            thr_q  <= cfg_data[CW-1:0];
            pen_q  <= cfg_data[CW];
            pol_q  <= cfg_data[CW+1];
            psel_q <= cfg_chan;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Evaluate one channel against its condition code.
        assign chan_ok[c] = trg_pkg::cond_hit(cond_q[c], cur[c], prev[c]);
    end

    trg_pulse_width #(.NCH(NCH), .CW(CW)) u_pw (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pen_q),
        .pol   (pol_q),
        .sel   (psel_q),
        .thr   (thr_q),
        .cur   (cur),
        .prev  (prev),
        .hit   (pw_hit)
    );

    // All channel conditions AND the qualifier, when enabled.
    always_comb match = (&chan_ok) & (~pen_q | pw_hit);

endmodule

// File: rtl/trg_sequencer.sv
`timescale 1ns/1ps
// Stage sequencer. It walks from stage 0 to the final stage, one advance per
// sample, emits a one-cycle trigger and then holds until it is re-armed.
// Assumes NSTAGE is a power of two so every index value names a stage.
module trg_sequencer #(
    parameter int NSTAGE = 4,
    localparam int SW = $clog2(NSTAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [NSTAGE-1:0] match_i,
    input  logic [SW-1:0]     last_i,
    output logic              trig_o,
    output logic [SW-1:0]     stage_o
);

    logic [SW-1:0] stage_q;
    logic          done_q;
    logic          trig_q;

    // Advance on a match of the awaited stage; fire on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            stage_q <= '0;
            done_q  <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (!done_q && match_i[stage_q]) begin
                if (stage_q >= last_i) begin
                    trig_q <= 1'b1;
                    done_q <= 1'b1;
                end else begin
                    stage_q <= stage_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        trig_o  = trig_q;
        stage_o = stage_q;
    end

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q); // R4
    AST_TRIG_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> $past(|match_i)); // R4
    AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (stage_q == '0 && !trig_q)); // R8
    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != $past(stage_q)) |-> (stage_q == $past(stage_q) + 1'b1 || stage_q == '0)); // R5

endmodule

// File: rtl/seq_trigger_engine.sv
`timescale 1ns/1ps
// Top of the sequenced trigger engine. It keeps the previous sample, holds the
// final-stage setting, instantiates one stage per parameter and the sequencer.
// Assumes chan is already synchronous to clk, one sample per clock.
module seq_trigger_engine #(
    parameter int NCH    = 32,
    parameter int NSTAGE = 4,
    parameter int CW     = 16,
    localparam int SW  = $clog2(NSTAGE),
    localparam int CHW = $clog2(NCH),
    localparam int DW  = CW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic [NCH-1:0] chan,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_kind,
    input  logic [SW-1:0]  cfg_stage,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [31:0]    cfg_data,
    output logic           trig,
    output logic [SW-1:0]  stage_idx
);

    logic [NCH-1:0]    prev_q;
    logic [SW-1:0]     last_q;
    logic [NSTAGE-1:0] stage_match;

    // Keep the previous sample for edge conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chan;
    end

    // Hold the final-stage setting, clamped to the last existing stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (cfg_we && cfg_kind == 2'd2) begin
            if (cfg_data >= 32'(NSTAGE - 1)) last_q <= SW'(NSTAGE - 1);
            else                             last_q <= cfg_data[SW-1:0];
        end
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        trg_stage #(.NCH(NCH), .CW(CW), .SW(SW), .IDX(s)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we),
            .cfg_kind  (cfg_kind),
            .cfg_stage (cfg_stage),
            .cfg_chan  (cfg_chan),
            .cfg_data  (cfg_data[DW-1:0]),
            .cur       (chan),
            .prev      (prev_q),
            .match     (stage_match[s])
        );
    end

    trg_sequencer #(.NSTAGE(NSTAGE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .match_i (stage_match),
        .last_i  (last_q),
        .trig_o  (trig),
        .stage_o (stage_idx)
    );

    AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_q == $past(chan))); // R2

endmodule

// File: tb/seq_trigger_engine_tb.sv
`timescale 1ns/1ps
module seq_trigger_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int NSTAGE = 4;
    localparam int SW = 2;
    localparam int CHW = 5;

    logic           clk;
    logic           rst_n;
    logic           arm;
    logic [NCH-1:0] chan;
    logic           cfg_we;
    logic [1:0]     cfg_kind;
    logic [SW-1:0]  cfg_stage;
    logic [CHW-1:0] cfg_chan;
    logic [31:0]    cfg_data;
    logic           trig;
    logic [SW-1:0]  stage_idx;

    int n_chk = 0;
    int n_bad = 0;

    seq_trigger_engine #(.NCH(NCH), .NSTAGE(NSTAGE), .CW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .chan(chan),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_stage(cfg_stage),
        .cfg_chan(cfg_chan), .cfg_data(cfg_data),
        .trig(trig), .stage_idx(stage_idx)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic cfg(input int kind, input int stg, input int ch, input int data);
        cfg_we    = 1'b1;
        cfg_kind  = kind[1:0];
        cfg_stage = stg[SW-1:0];
        cfg_chan  = ch[CHW-1:0];
        cfg_data  = data;
        step();
        cfg_we    = 1'b0;
    endtask

    function automatic int cond_model(input int code, input logic cur, input logic prev);
        case (code)
            1: return int'(cur);
            2: return int'(!cur);
            3: return int'(cur && !prev);
            4: return int'(!cur && prev);
            default: return 1;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic v;
        int   first;
        logic prevb;
        int   exp_t;
        logic [8:0] c0_seq;
        logic [8:0] c1_seq;
        int   stg_seq [9];

        rst_n = 1'b0; arm = 1'b0; chan = '0;
        cfg_we = 1'b0; cfg_kind = '0; cfg_stage = '0; cfg_chan = '0; cfg_data = '0;
        repeat (3) step();
        chk("R1", "trig in reset", int'(trig), 0);
        chk("R1", "stage in reset", int'(stage_idx), 0);
        rst_n = 1'b1;

        // R1 with R4: default ignore stage fires on the first armed sample, once.
        arm = 1'b1;
        step();
        chk("R1", "default stage fires", int'(trig), 1);
        step();
        chk("R4", "pulse is one cycle", int'(trig), 0);
        arm = 1'b0;
        step();

        // R2 / R9 sweep: every edge/level code on every channel, others toggling.
        for (int code = 1; code <= 4; code++) begin
            for (int c = 0; c < NCH; c++) begin
                arm = 1'b0; chan = '0;
                step();
                cfg(0, 0, c, code);
                arm = 1'b1;
                prevb = 1'b0;
                first = -1;
                for (int i = 0; i < 5; i++) begin
                    v = (i == 2 || i == 3);
                    chan = {NCH{i[0]}};
                    chan[c] = v;
                    if (first < 0 && cond_model(code, v, prevb) == 1) first = i;
                    step();
                    chk("R2", $sformatf("code %0d ch %0d sample %0d", code, c, i),
                        int'(trig), int'(first == i));
                    prevb = v;
                end
                arm = 1'b0;
                cfg(0, 0, c, 0);
            end
        end

        // R3: three channels combined, all eight value combinations.
        cfg(0, 0, 3, 1);
        cfg(0, 0, 7, 2);
        cfg(0, 0, 20, 3);
        for (int k = 0; k < 8; k++) begin
            arm = 1'b0; chan = '0;
            step();
            arm = 1'b1;
            chan[3] = k[0]; chan[7] = k[1]; chan[20] = k[2];
            step();
            chk("R3", $sformatf("combo %0d", k), int'(trig),
                int'(k[0] && !k[1] && k[2]));
        end
        arm = 1'b0;
        cfg(0, 0, 3, 0);
        cfg(0, 0, 7, 0);
        cfg(0, 0, 20, 0);

        // R5 / R8: header rise on ch0, ch1 high, tail fall on ch0.
        cfg(0, 0, 0, 3);
        cfg(0, 1, 1, 1);
        cfg(0, 2, 0, 4);
        cfg(2, 0, 0, 2);
        chan = '0;
        step();
        arm = 1'b1;
        c0_seq = 9'b010100110; // index 0 is bit 0
        c1_seq = 9'b111110011;
        stg_seq = '{0, 1, 1, 1, 2, 2, 2, 2, 2};
        for (int i = 0; i < 9; i++) begin
            chan = '0;
            chan[0] = c0_seq[i];
            chan[1] = c1_seq[i];
            step();
            exp_t = (i == 6) ? 1 : 0;
            chk("R5", $sformatf("sequence stage at %0d", i), int'(stage_idx), stg_seq[i]);
            chk("R8", $sformatf("sequence trig at %0d", i), int'(trig), exp_t);
        end
        arm = 1'b0;
        step();
        chk("R8", "disarm clears stage", int'(stage_idx), 0);
        chk("R8", "disarm no trig", int'(trig), 0);
        arm = 1'b1;
        chan = '0;
        chan[0] = 1'b1;
        step();
        chk("R5", "rearm header advances", int'(stage_idx), 1);
        arm = 1'b0;
        cfg(0, 0, 0, 0);
        cfg(0, 1, 1, 0);
        cfg(0, 2, 0, 0);
        cfg(2, 0, 0, 0);

        // R8: final match falls on a disarmed sample.
        cfg(0, 0, 2, 3);
        chan = '0;
        step();
        chan[2] = 1'b1;
        step();
        chk("R8", "match while disarmed", int'(trig), 0);
        arm = 1'b1;
        step();
        chk("R8", "level, no new edge", int'(trig), 0);
        chan[2] = 1'b0;
        step();
        chan[2] = 1'b1;
        step();
        chk("R8", "edge while armed", int'(trig), 1);
        arm = 1'b0;
        cfg(0, 0, 2, 0);

        // R6 / R7: glitch qualifier, both polarities, thresholds vs widths.
        for (int pol = 0; pol < 2; pol++) begin
            for (int t = 1; t <= 4; t++) begin
                for (int w = 1; w <= 5; w++) begin
                    arm = 1'b0;
                    chan = '0;
                    chan[5] = pol[0];
                    cfg(1, 0, 5, (1 << 16) | (pol << 17) | t);
                    step();
                    arm = 1'b1;
                    for (int i = 0; i <= w; i++) begin
                        chan[5] = (i < w) ? !pol[0] : pol[0];
                        step();
                        chk(pol == 0 ? "R6" : "R7",
                            $sformatf("thr %0d width %0d sample %0d", t, w, i),
                            int'(trig), int'(i == w && w < t));
                    end
                end
            end
        end
        arm = 1'b0;
        cfg(1, 0, 5, 0);
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule